// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Bus Registers

This block sits between a CPU bus and an external 8-bit analog front end with four inputs. Software writes one control/status register to pick a channel, power the converter and choose the conversion clock. From then on the block converts the chosen channel over and over, one result every 32 conversion-clock cycles. Each conversion is a successive-approximation search. The block drives a trial code to an external DAC and reads back one comparator bit, which is 1 when the analog input is at or above the DAC level. It settles one result bit per step, starting at the MSB.

Each finished result is written to a read-only result register and raises a completion flag. A new result replaces the old one whether or not the previous one was read. The flag drops on any write to the control register or on a read of the result register. Any control write also aborts the conversion in progress and starts a new one with the new settings.

The conversion clock is either the bus clock or an auxiliary clock that is asynchronous to it. In auxiliary mode a second sequencer runs in that domain. Its results come back through a toggle handshake. Results still in flight from before the latest control write are discarded.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the result register reads 0x00, `chan_sel` is 0, `adc_on` is 0 and `dac_code` is 0.
- R2: Control register layout (read with `bus_sel`=0): bit 7 = done flag (writes ignored), bit 6 = auxiliary clock select, bit 5 = converter on, bits 4:3 always read 0, bits 2:0 = channel. A write of 0xFF reads back 0x67. `chan_sel` and `adc_on` follow the written fields from the cycle after the write.
- R3: Every result equals the level of the selected channel as seen by the comparator. The result is the largest code for which the comparator reports input ≥ DAC code. Channel index = `chan_sel[1:0]`.
- R4: In bus-clock mode (bit 6 = 0), when a control write with bit 5 = 1 is sampled on clock edge E0, the done flag still reads 0 after edge E32 and reads 1 after edge E33.
- R5: Conversion repeats with no further write. In bus-clock mode, a new result is loaded every 32 cycles, even while the done flag is still set. The done flag stays set and the old value is overwritten.
- R6: A read strobe on the result register (`bus_sel`=1) clears the done flag. So does any control-register write. A result arriving on the same edge as a read leaves the flag set.
- R7: A control write during a conversion aborts it. The next flag comes 33 cycles after that write and carries the new channel's value.
- R8: While bit 5 is 0, no conversion runs. The done flag stays 0, `dac_code` stays 0 and the result register keeps its last value.
- R9: With bit 6 = 1, conversions are clocked by `aux_clk`. Their results reach the result register and the done flag through the clock crossing, with the correct value, repeatedly.
- R10: The search settles bits from MSB to LSB. The first 24 cycles of each 32-cycle slot drive `dac_code` = 0 for sampling. On cycle 24 of the slot, `dac_code` = 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset (bus domain; also synchronised into the auxiliary domain) |
| bus_sel | input | 1 | Register select: 0 = control/status, 1 = result |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| aux_clk | input | 1 | Auxiliary conversion clock, asynchronous to `clk` |
| cmp_bit | input | 1 | Comparator: 1 when analog input ≥ DAC level |
| dac_code | output | 8 | Trial code for the external DAC |
| chan_sel | output | 3 | Channel field for the external input multiplexer |
| adc_on | output | 1 | Analog power enable |

## Verification
The bench builds the block with its default parameters: a 32-cycle slot and two-stage synchronisers. With these, the 24-cycle sampling phase, the 0x80 first trial and the completion flag rising 33 bus cycles after a write can be checked cycle by cycle, and an overwrite can be caught between the 32nd and 33rd cycle of the second slot. The auxiliary clock runs at 13 ns against the 8 ns bus clock, so the toggle handshake, the discard of stale results after a restart and continuous results in the other domain are exercised with unrelated edge phases.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int DW = 8;
    localparam int CHW = 3;

    localparam logic SEL_CSR = 1'b0;
    localparam logic SEL_RES = 1'b1;

    typedef struct packed {
        logic           done;
        logic           aux_clk_sel;
        logic           power;
        logic [1:0]     zero;
        logic [CHW-1:0] chan;
    } csr_t;

    function automatic csr_t csr_from_write(input logic [DW-1:0] d);
        csr_t c;
        c      = csr_t'(d);
        c.done = 1'b0;
        c.zero = 2'b00;
        return c;
    endfunction

    function automatic logic [DW-1:0] msb_onehot();
        logic [DW-1:0] v;
        v         = '0;
        v[DW-1]   = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_adc_pkg::*;
#(
    parameter int SLOT = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic          cmp_bit,
    output logic [DW-1:0] dac_code,
    output logic [DW-1:0] res_data,
    output logic          res_done
);
    localparam int CW     = $clog2(SLOT);
    localparam int SETTLE = SLOT - DW;
    localparam logic [DW-1:0] TOP_BIT = msb_onehot();

    logic [CW-1:0] cnt;
    logic [CW-1:0] step;
    logic [DW-1:0] approx;
    logic [DW-1:0] trial;
    logic [DW-1:0] decided;
    logic          in_step;

    always_comb begin
        in_step = (cnt >= CW'(SETTLE));
        step    = cnt - CW'(SETTLE);
        trial   = in_step ? (TOP_BIT >> step) : '0;
        decided = approx | (cmp_bit ? trial : '0);
    end

    assign dac_code = approx | trial;

    always_ff @(posedge clk) begin
        if (rst || !en || restart) begin
            cnt      <= '0;
            approx   <= '0;
            res_done <= 1'b0;
        end else begin
            res_done <= 1'b0;
            if (cnt == CW'(SLOT - 1)) begin
                cnt      <= '0;
                approx   <= '0;
                res_done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                if (in_step) approx <= decided;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data <= '0;
        end else if (en && !restart && cnt == CW'(SLOT - 1)) begin
            res_data <= decided;
        end
    end

    // R8: a stopped sequencer presents a zero code
    p_idle_dac_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (dac_code == '0));

    // R5: one completion pulse per slot
    p_done_gap_r5: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int SLOT_CYC   = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           aux_clk,
    input  logic           cmp_bit,
    output logic [DW-1:0]  dac_code,
    output logic [CHW-1:0] chan_sel,
    output logic           adc_on
);
    csr_t          csr;
    logic [DW-1:0] result;
    logic          wr_csr, rd_res;
    logic          cfg_tgl;

    assign wr_csr = bus_wr && (bus_sel == SEL_CSR);
    assign rd_res = bus_rd && (bus_sel == SEL_RES);

    // bus-clock sequencer
    logic          run_s;
    logic [DW-1:0] dac_s, res_s;
    logic          done_s;

    assign run_s = csr.power && !csr.aux_clk_sel;

    sar_engine #(.SLOT(SLOT_CYC)) u_eng_bus (
        .clk(clk), .rst(rst), .en(run_s), .restart(wr_csr), .cmp_bit(cmp_bit),
        .dac_code(dac_s), .res_data(res_s), .res_done(done_s)
    );

    // auxiliary domain
    logic [1:0] aux_rst_pipe;
    logic       aux_rst;

    always_ff @(posedge aux_clk) aux_rst_pipe <= {aux_rst_pipe[0], rst};
    assign aux_rst = aux_rst_pipe[1];

    logic [1:0]    ctl_a;
    logic          cfg_a, run_a, ack_a, restart_a, res_tgl_a;
    logic [DW-1:0] dac_a, res_a;
    logic          done_a;

    sync_bits #(.W(2), .STAGES(SYNC_DEPTH)) u_sync_to_aux (
        .clk(aux_clk), .rst(aux_rst),
        .d({cfg_tgl, csr.power && csr.aux_clk_sel}), .q(ctl_a)
    );
    assign cfg_a     = ctl_a[1];
    assign run_a     = ctl_a[0];
    assign restart_a = cfg_a ^ ack_a;

    sar_engine #(.SLOT(SLOT_CYC)) u_eng_aux (
        .clk(aux_clk), .rst(aux_rst), .en(run_a), .restart(restart_a), .cmp_bit(cmp_bit),
        .dac_code(dac_a), .res_data(res_a), .res_done(done_a)
    );

    always_ff @(posedge aux_clk) begin
        if (aux_rst) begin
            ack_a     <= 1'b0;
            res_tgl_a <= 1'b0;
        end else begin
            ack_a <= cfg_a;
            if (done_a) res_tgl_a <= ~res_tgl_a;
        end
    end

    // back into the bus domain
    logic [1:0] back_s;
    logic       rt_s, ack_s, rt_prev, aux_new;

    sync_bits #(.W(2), .STAGES(SYNC_DEPTH)) u_sync_to_bus (
        .clk(clk), .rst(rst), .d({res_tgl_a, ack_a}), .q(back_s)
    );
    assign rt_s  = back_s[1];
    assign ack_s = back_s[0];

    always_ff @(posedge clk) begin
        if (rst) rt_prev <= 1'b0;
        else     rt_prev <= rt_s;
    end

    assign aux_new = (rt_s != rt_prev) && (ack_s == cfg_tgl) && csr.power && csr.aux_clk_sel;

    logic          new_res;
    logic [DW-1:0] new_val;

    assign new_res = done_s || aux_new;
    assign new_val = done_s ? res_s : res_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            csr     <= '0;
            result  <= '0;
            cfg_tgl <= 1'b0;
        end else if (wr_csr) begin
            csr     <= csr_from_write(bus_wdata);
            cfg_tgl <= ~cfg_tgl;
        end else if (new_res) begin
            csr.done <= 1'b1;
            result   <= new_val;
        end else if (rd_res) begin
            csr.done <= 1'b0;
        end
    end

    assign bus_rdata = (bus_sel == SEL_CSR) ? DW'(csr) : result;
    assign dac_code  = csr.aux_clk_sel ? dac_a : dac_s;
    assign chan_sel  = csr.chan;
    assign adc_on    = csr.power;

    // R6: control write drops the flag
    p_wr_clears_r6: assert property (@(posedge clk) disable iff (rst)
        wr_csr |=> !bus_rdata[7] || bus_sel);

    // R6: result read drops the flag unless a result lands
    p_rd_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_res && !new_res && !wr_csr) |=> !csr.done);

    // R5: a landing result sets the flag even if already set
    p_new_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (new_res && !wr_csr) |=> csr.done);

    // R2: channel output follows the written field
    p_chan_follow_r2: assert property (@(posedge clk) disable iff (rst)
        wr_csr |=> (chan_sel == $past(bus_wdata[CHW-1:0])));

endmodule

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
    logic       clk = 1'b0;
    logic       aux_clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, dac_code;
    logic [2:0] chan_sel;
    logic       adc_on, cmp_bit;
    logic [7:0] vin [4];

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    always #6.5 aux_clk = ~aux_clk;

    assign cmp_bit = (vin[chan_sel[1:0]] >= dac_code);

    sar_adc_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aux_clk(aux_clk),
        .cmp_bit(cmp_bit), .dac_code(dac_code), .chan_sel(chan_sel), .adc_on(adc_on)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] peek(input logic a);
        return a ? u_dut.bus_rdata : 8'h00;
    endfunction

    task automatic look(input logic a, output logic [7:0] v);
        bus_sel = a; #1 v = bus_rdata; bus_sel = 1'b0; #1;
    endtask

    // scoreboard
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         mon_arm = 0;

    task automatic expect_result(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        mon_arm = 1;
        wait (!mon_arm);
    endtask

    initial begin : monitor
        logic [7:0] got, e;
        string      t;
        forever begin
            @(negedge clk);
            if (mon_arm && bus_rdata[7] && !bus_sel) begin
                bus_sel = 1'b1; bus_rd = 1'b1;
                #1 got = bus_rdata;
                @(posedge clk);
                #1 bus_rd = 1'b0; bus_sel = 1'b0;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, t, got, e);
                mon_arm = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] v;
        vin[0] = 8'h5A; vin[1] = 8'h00; vin[2] = 8'hFF; vin[3] = 8'h80;
        repeat (10) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1
        look(1'b0, v); check(v == 8'h00, "R1 csr reset", v, 0);
        look(1'b1, v); check(v == 8'h00, "R1 result reset", v, 0);
        check(chan_sel == 0 && adc_on == 0 && dac_code == 0, "R1 outputs reset",
              {chan_sel, adc_on, dac_code}, 0);

        // R2
        bus_write(1'b0, 8'hFF);
        @(negedge clk);
        look(1'b0, v); check(v == 8'h67, "R2 csr layout", v, 8'h67);
        check(chan_sel == 3'd7 && adc_on, "R2 chan/on outputs", {chan_sel, adc_on}, 8'hF);
        bus_write(1'b0, 8'h00);
        @(negedge clk);
        look(1'b0, v); check(v == 8'h00, "R2 csr cleared", v, 0);

        // R10 / R4 / R3 on channel 0
        bus_write(1'b0, 8'h20);
        @(negedge clk);
        check(dac_code == 8'h00, "R10 sampling code", dac_code, 0);
        repeat (24) @(posedge clk);
        @(negedge clk);
        check(dac_code == 8'h80, "R10 first trial MSB", dac_code, 8'h80);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R4 flag low after 32", bus_rdata[7], 0);
        @(posedge clk);
        @(negedge clk);
        check(bus_rdata[7] == 1'b1, "R4 flag high after 33", bus_rdata[7], 1);
        expect_result(8'h5A, "R3 ch0 value");
        @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R6 read clears flag", bus_rdata[7], 0);

        // R3 other channels
        for (int ch = 1; ch < 4; ch++) begin
            bus_write(1'b0, 8'h20 | 8'(ch));
            expect_result(vin[ch], $sformatf("R3 ch%0d value", ch));
        end

        // R5 overwrite while flag set
        vin[0] = 8'h11;
        bus_write(1'b0, 8'h20);
        repeat (33) @(posedge clk);
        @(negedge clk);
        vin[0] = 8'h22;
        look(1'b1, v); check(v == 8'h11, "R5 first result", v, 8'h11);
        repeat (31) @(posedge clk);
        @(negedge clk);
        look(1'b1, v); check(v == 8'h11, "R5 before overwrite", v, 8'h11);
        @(posedge clk);
        @(negedge clk);
        look(1'b1, v); check(v == 8'h22, "R5 overwritten", v, 8'h22);
        look(1'b0, v); check(v[7] == 1'b1, "R5 flag kept", v[7], 1);

        // R6 write clears flag, R7 abort/restart
        bus_write(1'b0, 8'h20);
        @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R6 write clears flag", bus_rdata[7], 0);
        repeat (20) @(posedge clk);
        bus_write(1'b0, 8'h21);
        repeat (32) @(posedge clk);
        @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R7 no flag at 32", bus_rdata[7], 0);
        @(posedge clk);
        @(negedge clk);
        check(bus_rdata[7] == 1'b1, "R7 flag at 33", bus_rdata[7], 1);
        expect_result(8'h00, "R7 new channel value");

        // R8 powered off
        bus_write(1'b0, 8'h00);
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(bus_rdata[7] == 1'b0, "R8 no flag when off", bus_rdata[7], 0);
        check(dac_code == 8'h00, "R8 dac idle", dac_code, 0);
        look(1'b1, v); check(v == 8'h00, "R8 result kept", v, 0);

        // R9 auxiliary clock
        vin[2] = 8'hA7;
        bus_write(1'b0, 8'h62);
        expect_result(8'hA7, "R9 aux first result");
        expect_result(8'hA7, "R9 aux repeated result");
        vin[2] = 8'h3C;
        bus_write(1'b0, 8'h62);
        expect_result(8'h3C, "R9 aux after restart");
        bus_write(1'b0, 8'h00);

        repeat (5) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule